// File: doc/BRIEF.md
# Instruction Fetch Stage with Parked Redirects

This block is the front stage of a 32-bit pipelined processor. It keeps the program counter, asks an instruction-cache read port for one word at a time, and hands each instruction to decode together with the address it came from. Decode applies back-pressure with a stall input. While the stall is high, the fetch output holds its value and no new read starts.

Later pipeline stages steer the stage with redirect requests. A redirect that arrives while the stage is idle and not stalled moves the PC at once. A redirect that arrives while a cache read is waiting, or while the stage is stalled, is parked in a single-entry slot. The parked redirect takes effect as soon as the stage is free to move.

A newer redirect always replaces a parked one. An older instruction that resolves late, such as a multi-register load that writes the PC, can raise its redirect after a younger branch already has. Only the last request must win. An instruction returned for a read that was in flight when a redirect arrived belongs to the wrong path. It is discarded and never reaches decode.

Top module: `ifetch_redirect`

## Requirements
- R1: While reset is low, `dec_vld` and `ic_req` are 0. In the first cycle after reset is released with `fe_stall` low, the stage starts a read at address 0.
- R2: Each instruction that reaches decode without an intervening redirect has `dec_pc` equal to the previous accepted `dec_pc` plus 4. Its `dec_insn` is the word the cache returned for that address.
- R3: A redirect seen in a cycle with no read pending and `fe_stall` low loads the PC on that clock. The next read then starts at the redirect target, one cycle later.
- R4: A redirect seen while a read is pending is parked. The word returned for that read, including one returned in the same cycle as the redirect, is never presented to decode. The next read starts at the target.
- R5: A redirect seen while `fe_stall` is high and no read is pending is parked. It is applied in the first unstalled cycle, and the following read starts at its target.
- R6: When a second redirect arrives while one is parked, the newer target replaces the older one. Only the newer target is ever fetched.
- R7: While `fe_stall` is high, `dec_vld`, `dec_insn` and `dec_pc` hold their values across the clock edge.
- R8: Once `ic_req` is raised, it stays high with a stable `ic_addr` until a cycle in which `ic_ack` is high.
- R9: No new read starts in a cycle in which `fe_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fe_stall | input | 1 | Decode back-pressure. Holds the output and blocks new reads |
| redir_vld | input | 1 | Redirect request from a later stage, one cycle per request |
| redir_pc | input | 32 | Redirect target address |
| ic_req | output | 1 | Read request to the instruction cache, held until acknowledged |
| ic_addr | output | 32 | Word address of the pending read |
| ic_ack | input | 1 | Cache has `ic_rdata` valid for the held request. Stays high while `ic_req` stays high |
| ic_rdata | input | 32 | Instruction word returned by the cache |
| dec_vld | output | 1 | Instruction presented to decode is valid |
| dec_insn | output | 32 | Instruction presented to decode |
| dec_pc | output | 32 | Address of the presented instruction |

## Verification
A corrupted parked slot shows as a wrong `ic_addr` on the first request after a redirect. That request appears one or two cycles after the pending read ends or the stall drops. It also shows as a `dec_pc` that breaks the plus-4 chain on the next fresh instruction.

A read-pending flag that is set when it should be clear shows as `ic_req` that stays high or rises while stalled, in the very next cycle. A missed wrong-path discard shows as a stale instruction reaching decode one cycle after the ack.

The bench therefore follows every fresh decode handoff against an address chain it rebuilds from its own redirects. It also watches the request address right after each redirect.

// File: rtl/ifetch_pkg.sv
// Shared types for the fetch stage.
package ifetch_pkg;
    // Source of the next program counter value.
    typedef enum logic [1:0] {
        PC_HOLD  = 2'd0,
        PC_SEQ   = 2'd1,
        PC_JUMP  = 2'd2,
        PC_QUEUE = 2'd3
    } pc_sel_e;
endpackage

// File: rtl/ifetch_pc.sv
// Program counter register.
// Assumes: sel is one-hot in meaning; PC_HOLD keeps the value.
// The PC doubles as the address of the pending cache read.
module ifetch_pc
    import ifetch_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int STEP = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         sel,
    input  logic [XLEN-1:0] jump_pc,
    input  logic [XLEN-1:0] queue_pc,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] INC = XLEN'(STEP);

    logic [XLEN-1:0] pc_nxt;

    // Pick the next PC from the selected source.
    always_comb begin
        unique case (sel)
            PC_SEQ:   pc_nxt = pc + INC;
            PC_JUMP:  pc_nxt = jump_pc;
            PC_QUEUE: pc_nxt = queue_pc;
            default:  pc_nxt = pc;
        endcase
    end

    // Register the PC, reset to the boot address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc_nxt;
    end
endmodule

// File: rtl/ifetch_jmpq.sv
// One-entry parking slot for redirect targets.
// Assumes: load and clear never both matter in one cycle. If they do,
// load wins, so a newer target is never lost. A load over a full slot
// overwrites the older target.
module ifetch_jmpq #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] load_pc,
    input  logic            clear,
    output logic            full,
    output logic [XLEN-1:0] slot_pc
);
    // Track slot occupancy: load sets, clear empties.
    always_ff @(posedge clk) begin
        if (!rst_n)     full <= 1'b0;
        else if (load)  full <= 1'b1;
        else if (clear) full <= 1'b0;
    end

    // Capture the newest target; no reset needed on the data.
    always_ff @(posedge clk) begin
        if (load) slot_pc <= load_pc;
    end
endmodule

// File: rtl/ifetch_rdtrk.sv
// Read-pending tracker for the cache port.
// Assumes: issue only when idle, done only when pending.
module ifetch_rdtrk (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic done,
    output logic pending
);
    // Set on issue, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (issue) pending <= 1'b1;
        else if (done)  pending <= 1'b0;
    end
endmodule

// File: rtl/ifetch_outreg.sv
// Output register toward decode.
// Assumes: hold is decode's stall. While it is high, nothing changes.
// Otherwise the valid bit follows load, and the data is captured on load.
module ifetch_outreg #(
    parameter int XLEN   = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic [INSN_W-1:0] insn_in,
    input  logic [XLEN-1:0]   pc_in,
    output logic              vld,
    output logic [INSN_W-1:0] insn,
    output logic [XLEN-1:0]   pc
);
    // Valid bit: frozen under hold, else a bubble unless loading.
    always_ff @(posedge clk) begin
        if (!rst_n)    vld <= 1'b0;
        else if (!hold) vld <= load;
    end

    // Payload: captured only on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn <= '0;
            pc   <= '0;
        end else if (!hold && load) begin
            insn <= insn_in;
            pc   <= pc_in;
        end
    end
endmodule

// File: rtl/ifetch_redirect.sv
// Fetch stage top.
// Issues one word read at a time, presents results to decode, and
// applies redirects directly when idle or via a one-entry slot otherwise.
// Assumes: the cache holds ic_ack/ic_rdata while ic_req stays high.
// A parked redirect can only exist while a read is pending if it
// arrived during that read, so a full slot marks the read wrong-path.
module ifetch_redirect
    import ifetch_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int INSN_W = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fe_stall,
    input  logic              redir_vld,
    input  logic [XLEN-1:0]   redir_pc,
    output logic              ic_req,
    output logic [XLEN-1:0]   ic_addr,
    input  logic              ic_ack,
    input  logic [INSN_W-1:0] ic_rdata,
    output logic              dec_vld,
    output logic [INSN_W-1:0] dec_insn,
    output logic [XLEN-1:0]   dec_pc
);
    localparam int STEP = INSN_W / 8;

    logic            pending;
    logic            slot_full;
    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] pc;
    logic            free;
    logic            wrong_path;
    logic            rd_done;
    logic            rd_good;
    logic            rd_issue;
    logic            park;
    logic            unpark;
    pc_sel_e         pc_sel;

    // Stage control: completion, discard, issue, parking and PC source.
    always_comb begin
        free       = !pending && !fe_stall;
        wrong_path = slot_full || redir_vld;
        rd_done    = pending && ic_ack && (wrong_path || !fe_stall);
        rd_good    = rd_done && !wrong_path;
        rd_issue   = free && !redir_vld && !slot_full;
        park       = redir_vld && (pending || fe_stall);
        unpark     = free;
        if (free && redir_vld)      pc_sel = PC_JUMP;
        else if (free && slot_full) pc_sel = PC_QUEUE;
        else if (rd_good)           pc_sel = PC_SEQ;
        else                        pc_sel = PC_HOLD;
    end

    ifetch_pc #(
        .XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .sel(pc_sel),
        .jump_pc(redir_pc), .queue_pc(slot_pc), .pc(pc)
    );

    ifetch_jmpq #(.XLEN(XLEN)) u_jmpq (
        .clk(clk), .rst_n(rst_n), .load(park), .load_pc(redir_pc),
        .clear(unpark), .full(slot_full), .slot_pc(slot_pc)
    );

    ifetch_rdtrk u_rdtrk (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .done(rd_done),
        .pending(pending)
    );

    ifetch_outreg #(.XLEN(XLEN), .INSN_W(INSN_W)) u_out (
        .clk(clk), .rst_n(rst_n), .hold(fe_stall), .load(rd_good),
        .insn_in(ic_rdata), .pc_in(pc),
        .vld(dec_vld), .insn(dec_insn), .pc(dec_pc)
    );

    // Drive the cache port from the tracker and the PC.
    always_comb begin
        ic_req  = pending;
        ic_addr = pc;
    end
endmodule

// File: rtl/ifetch_redirect_chk.sv
// Port-level property checker for the fetch stage.
module ifetch_redirect_chk #(
    parameter int XLEN   = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fe_stall,
    input logic              redir_vld,
    input logic [XLEN-1:0]   redir_pc,
    input logic              ic_req,
    input logic [XLEN-1:0]   ic_addr,
    input logic              ic_ack,
    input logic              dec_vld,
    input logic [INSN_W-1:0] dec_insn,
    input logic [XLEN-1:0]   dec_pc
);
    // R7
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_stall |=> ($stable(dec_vld) && $stable(dec_insn) && $stable(dec_pc)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req && !ic_ack) |=> (ic_req && $stable(ic_addr)));

    // R9
    no_issue_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ic_req && fe_stall) |=> !ic_req);

    // R3
    direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ic_req && !fe_stall && redir_vld) |=> (!ic_req && ic_addr == $past(redir_pc)));

    // R4
    wrong_path_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req && ic_ack && redir_vld && !fe_stall) |=> !dec_vld);
endmodule

bind ifetch_redirect ifetch_redirect_chk #(.XLEN(XLEN), .INSN_W(INSN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fe_stall(fe_stall), .redir_vld(redir_vld),
    .redir_pc(redir_pc), .ic_req(ic_req), .ic_addr(ic_addr), .ic_ack(ic_ack),
    .dec_vld(dec_vld), .dec_insn(dec_insn), .dec_pc(dec_pc)
);

// File: tb/sim_ifetch_redirect.sv
module sim_ifetch_redirect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe_stall = 1'b0;
    logic        redir_vld = 1'b0;
    logic [31:0] redir_pc = '0;
    logic        ic_req;
    logic [31:0] ic_addr;
    logic        ic_ack = 1'b0;
    logic [31:0] ic_rdata = '0;
    logic        dec_vld;
    logic [31:0] dec_insn;
    logic [31:0] dec_pc;

    int checks = 0;
    int errors = 0;
    int cache_lat = 0;
    int lat_cnt = 0;
    logic [31:0] exp_pc = '0;
    logic        done_flag = 1'b0;

    always #5 clk = ~clk;

    ifetch_redirect u0 (
        .clk(clk), .rst_n(rst_n), .fe_stall(fe_stall), .redir_vld(redir_vld),
        .redir_pc(redir_pc), .ic_req(ic_req), .ic_addr(ic_addr), .ic_ack(ic_ack),
        .ic_rdata(ic_rdata), .dec_vld(dec_vld), .dec_insn(dec_insn), .dec_pc(dec_pc)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'd3) ^ 32'h5A3C_0F11;
    endfunction

    // Cache model: ack after cache_lat cycles, held while the request stays.
    always @(negedge clk) begin
        if (!rst_n || !ic_req) begin
            ic_ack  = 1'b0;
            lat_cnt = 0;
        end else if (lat_cnt >= cache_lat) begin
            ic_ack   = 1'b1;
            ic_rdata = mem_word(ic_addr);
        end else begin
            lat_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, then check the port behavior at the next negedge.
    task automatic step(input bit st, input bit jr, input logic [31:0] jt);
        bit          take;
        bit          was_idle;
        logic        v0;
        logic [31:0] i0;
        logic [31:0] p0;
        fe_stall  = st;
        redir_vld = jr;
        redir_pc  = jt;
        take      = !dec_vld || !st;
        was_idle  = !ic_req;
        v0 = dec_vld; i0 = dec_insn; p0 = dec_pc;
        if (jr) exp_pc = jt;
        @(posedge clk);
        @(negedge clk);
        redir_vld = 1'b0;
        if (st) begin
            // R7 output frozen under stall
            chk(dec_vld == v0 && dec_insn == i0 && dec_pc == p0, "R7 stall hold", dec_pc, p0);
            // R9 no new read while stalled
            if (was_idle) chk(!ic_req, "R9 no issue under stall", 32'(ic_req), 32'd0);
        end
        if (dec_vld && take) begin
            // R2 / R4 / R6 fresh instruction follows the address chain
            chk(dec_pc == exp_pc, "R2 R4 R6 dec_pc chain", dec_pc, exp_pc);
            chk(dec_insn == mem_word(dec_pc), "R2 dec_insn data", dec_insn, mem_word(dec_pc));
            exp_pc = dec_pc + 32'd4;
        end
    endtask

    task automatic wait_req(input bit level);
        for (int k = 0; k < 40; k++) begin
            if (ic_req == level) return;
            step(1'b0, 1'b0, '0);
        end
        chk(1'b0, "wait for request level", 32'(ic_req), 32'(level));
    endtask

    // Wait for the next read request and check its address.
    task automatic next_req_addr(input logic [31:0] exp, input string tag);
        wait_req(1'b0);
        wait_req(1'b1);
        chk(ic_addr == exp, tag, ic_addr, exp);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!dec_vld, "R1 dec_vld in reset", 32'(dec_vld), 32'd0);
        chk(!ic_req, "R1 ic_req in reset", 32'(ic_req), 32'd0);
        rst_n = 1'b1;
        exp_pc = '0;
        step(1'b0, 1'b0, '0);
        chk(ic_req && ic_addr == 32'd0, "R1 first read at 0", ic_addr, 32'd0);

        // R2 sequential run, zero latency
        repeat (12) step(1'b0, 1'b0, '0);

        // R3 direct redirect when idle
        wait_req(1'b0);
        step(1'b0, 1'b1, 32'h0000_1000);
        chk(!ic_req && ic_addr == 32'h0000_1000, "R3 PC loaded next clock", ic_addr, 32'h0000_1000);
        step(1'b0, 1'b0, '0);
        chk(ic_req && ic_addr == 32'h0000_1000, "R3 read at target", ic_addr, 32'h0000_1000);
        repeat (6) step(1'b0, 1'b0, '0);

        // R4 redirect during a long read
        cache_lat = 5;
        wait_req(1'b0);
        wait_req(1'b1);
        step(1'b0, 1'b1, 32'h0000_2040);
        next_req_addr(32'h0000_2040, "R4 read at parked target");
        repeat (10) step(1'b0, 1'b0, '0);

        // R6 two redirects during one read: newer wins
        cache_lat = 6;
        wait_req(1'b0);
        wait_req(1'b1);
        step(1'b0, 1'b1, 32'h0000_3000);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 32'h0000_4400);
        next_req_addr(32'h0000_4400, "R6 newer target fetched");
        repeat (12) step(1'b0, 1'b0, '0);

        // R5 redirect while stalled and idle
        cache_lat = 0;
        wait_req(1'b0);
        step(1'b1, 1'b1, 32'h0000_5500);
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b0, '0);
        chk(!ic_req, "R5 nothing issued while stalled", 32'(ic_req), 32'd0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        chk(ic_req && ic_addr == 32'h0000_5500, "R5 read at parked target", ic_addr, 32'h0000_5500);
        repeat (6) step(1'b0, 1'b0, '0);

        // Random mix of stalls, redirects and latencies
        for (int n = 0; n < 4000; n++) begin
            if (n % 16 == 0) cache_lat = int'($urandom_range(0, 3));
            step(($urandom_range(0, 3) == 0), ($urandom_range(0, 24) == 0),
                 {16'h0, 14'($urandom), 2'b00});
        end
        repeat (20) step(1'b0, 1'b0, '0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule